// File: doc/BRIEF.md
# Watchdog Wakeup Reset Supervisor

This block supervises a microcontroller that spends most of its time asleep. It drives a free-running wakeup square wave that prompts the controller to come out of sleep, and it watches a watchdog input for the controller's answer: a falling edge. The first such edge in a wakeup cycle drops the wakeup line early and arms the next cycle. If a whole cycle passes with no edge, the block issues a timed active-low reset. After that reset, wakeup stays quiet for half a period and then restarts.

A power-good level, produced elsewhere by an analog comparator, also holds the reset low. Reset is released only once power has been good for a fixed delay. Every interval is counted in ticks of an internal timebase, and a tick is a fixed number of clock cycles. One period parameter sets the three ratios: the wakeup period is T ticks, the reset pulse is T/8 ticks and the restart gap is T/2 ticks. Both asynchronous inputs are synchronized. The watchdog input is also filtered, so that short glitches cannot act as a response.

Top module: `wake_watch_sup`

## Requirements
- R1: While arst_n is low, reset_n is 0 and wakeup is 0.
- R2: While power_good is low, reset_n stays 0. After power_good rises and stays high, reset_n rises once T/8 ticks have been counted. With 2 synchronizer stages this falls between (T/8-1)*TICK_DIV+3 and (T/8)*TICK_DIV+2 clocks after the input change.
- R3: After every rise of reset_n, wakeup stays 0 for exactly T/2 ticks (T/2*TICK_DIV clocks) and then rises.
- R4: When the controller responds only during the low phase, wakeup is 1 for T/2*TICK_DIV clocks of each period of T*TICK_DIV clocks.
- R5: A filtered wdi falling edge while wakeup is 1 drives wakeup to 0 exactly WDI_FILT+2 clocks after wdi changes. Wakeup stays 0 until the next cycle starts, so the cycle length is unchanged.
- R6: Only the first wdi falling edge in a cycle counts. Extra edges in the same cycle do not carry over as a response for the following cycle.
- R7: A cycle with no wdi falling edge makes reset_n fall exactly T*TICK_DIV clocks after that cycle's wakeup rise. With power_good high, reset_n stays low for exactly T/8*TICK_DIV clocks.
- R8: Wakeup is 0 whenever reset_n is 0.
- R9: A wdi level that lasts fewer than WDI_FILT consecutive clock samples is ignored. A low glitch of that length neither drops wakeup nor counts as a response.
- R10: A drop of power_good drives reset_n low 3 clocks later. A drop during a watchdog reset pulse restarts the T/8 delay, which is counted again from the return of power_good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| power_good | input | 1 | Supply-in-regulation level, asynchronous |
| wdi | input | 1 | Watchdog response from the controller, asynchronous |
| wakeup | output | 1 | Periodic wakeup square wave |
| reset_n | output | 1 | Active-low reset to the controller |

## Verification
The assertions take power_good and wdi as levels that change at any time. They relate only the synchronized copies, the filtered falling-edge event and the tick strobe to the outputs. Exact response latency and the acceptance of pulse widths assume that wdi holds each level for at least WDI_FILT clocks and that no response lands within the last few clocks of a cycle. The stimulus holds every real pulse for 8 clocks, a multiple of the filter length. It places random responses at offsets between 4 and 40 clocks into a phase that lasts 64 clocks, and it keeps power_good changes dozens of clocks apart.

// File: rtl/wws_pkg.sv
package wws_pkg;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,  // reset asserted
    PH_GAP  = 2'd1,  // reset released, waiting before first wakeup
    PH_RUN  = 2'd2   // wakeup cycles running
  } phase_t;

  // wakeup high phase and restart gap length in ticks
  function automatic int half_span(input int period);
    return period / 2;
  endfunction

  // reset pulse length in ticks
  function automatic int rst_span(input int period);
    return period / 8;
  endfunction

endpackage

// File: rtl/wws_tick.sv
module wws_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [DW-1:0] LAST_C = DW'(DIV - 1);
      logic [DW-1:0] cnt;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)            cnt <= '0;
        else if (cnt == LAST_C) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST_C);
    end
  endgenerate
endmodule

// File: rtl/wws_sync.sv
module wws_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_st
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh[0] <= RST_VAL;
          else         sh[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh[g] <= RST_VAL;
          else         sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wws_filt.sv
module wws_filt #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic s,
  output logic fall
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] END_C = CW'(LEN - 1);

  logic          lvl;
  logic [CW-1:0] cnt;
  logic          flip;

  // a new level is accepted after LEN consecutive differing samples
  assign flip = (s != lvl) && (cnt == END_C);
  assign fall = flip && lvl;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lvl <= 1'b1;
      cnt <= '0;
    end else if (s == lvl) begin
      cnt <= '0;
    end else if (flip) begin
      lvl <= s;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wws_seq.sv
module wws_seq
  import wws_pkg::*;
#(
  parameter int PERIOD = 32
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic pg_ok,
  input  logic kick,
  output logic wake,
  output logic rst_n,
  output logic miss
);
  localparam int HALF   = half_span(PERIOD);
  localparam int EIGHTH = rst_span(PERIOD);
  localparam int CW     = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST_C     = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF_C     = CW'(HALF);
  localparam logic [CW-1:0] HALF_END_C = CW'(HALF - 1);
  localparam logic [CW-1:0] RST_END_C  = CW'(EIGHTH - 1);

  phase_t        ph, ph_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          kicked, kicked_d;
  logic          cyc_end;

  assign cyc_end = (ph == PH_RUN) && tick && (cnt == LAST_C);
  assign miss    = cyc_end && !(kicked || kick);

  always_comb begin
    ph_d     = ph;
    cnt_d    = cnt;
    kicked_d = kicked || ((ph == PH_RUN) && kick);
    if (!pg_ok) begin
      ph_d     = PH_HOLD;
      cnt_d    = '0;
      kicked_d = 1'b0;
    end else begin
      unique case (ph)
        PH_HOLD: begin
          kicked_d = 1'b0;
          if (tick) begin
            if (cnt == RST_END_C) begin
              ph_d  = PH_GAP;
              cnt_d = '0;
            end else begin
              cnt_d = cnt + 1'b1;
            end
          end
        end
        PH_GAP: begin
          kicked_d = 1'b0;
          if (tick) begin
            if (cnt == HALF_END_C) begin
              ph_d  = PH_RUN;
              cnt_d = '0;
            end else begin
              cnt_d = cnt + 1'b1;
            end
          end
        end
        PH_RUN: begin
          if (cyc_end) begin
            cnt_d    = '0;
            kicked_d = 1'b0;
            if (miss) ph_d = PH_HOLD;
          end else if (tick) begin
            cnt_d = cnt + 1'b1;
          end
        end
        default: begin
          ph_d     = PH_HOLD;
          cnt_d    = '0;
          kicked_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph     <= PH_HOLD;
      cnt    <= '0;
      kicked <= 1'b0;
    end else begin
      ph     <= ph_d;
      cnt    <= cnt_d;
      kicked <= kicked_d;
    end
  end

  assign wake  = (ph == PH_RUN) && (cnt < HALF_C) && !kicked;
  assign rst_n = (ph != PH_HOLD);
endmodule

// File: rtl/wake_watch_sup.sv
module wake_watch_sup #(
  parameter int TICK_DIV     = 4,   // clocks per timebase tick
  parameter int PERIOD_TICKS = 32,  // wakeup period, multiple of 8
  parameter int WDI_FILT     = 4,   // stable samples to accept a wdi level
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic power_good,
  input  logic wdi,
  output logic wakeup,
  output logic reset_n
);
  // named internal events, also observed by the bound checker
  logic tick;
  logic pg_s;
  logic wdi_s;
  logic wdi_fall;
  logic miss;

  wws_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .arst_n(arst_n), .tick(tick)
  );

  wws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .arst_n(arst_n), .d(power_good), .q(pg_s)
  );

  wws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wdi_sync (
    .clk(clk), .arst_n(arst_n), .d(wdi), .q(wdi_s)
  );

  wws_filt #(.LEN(WDI_FILT)) u_filt (
    .clk(clk), .arst_n(arst_n), .s(wdi_s), .fall(wdi_fall)
  );

  wws_seq #(.PERIOD(PERIOD_TICKS)) u_seq (
    .clk(clk), .arst_n(arst_n), .tick(tick), .pg_ok(pg_s),
    .kick(wdi_fall), .wake(wakeup), .rst_n(reset_n), .miss(miss)
  );
endmodule

// File: rtl/wake_watch_sup_chk.sv
module wake_watch_sup_chk (
  input logic clk,
  input logic arst_n,
  input logic tick,
  input logic pg_s,
  input logic wdi_s,
  input logic wdi_fall,
  input logic miss,
  input logic wakeup,
  input logic reset_n
);
  p_wake_low_in_reset_r8: assert property (@(posedge clk) disable iff (!arst_n)
    !reset_n |-> !wakeup);

  p_pg_low_forces_reset_r10: assert property (@(posedge clk) disable iff (!arst_n)
    !pg_s |=> !reset_n);

  p_kick_drops_wake_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (wdi_fall && wakeup) |=> !wakeup);

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(reset_n) |-> $past(tick));

  p_wake_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(wakeup) |-> $past(tick));

  p_miss_resets_r7: assert property (@(posedge clk) disable iff (!arst_n)
    miss |=> !reset_n);

  p_fall_needs_low_r9: assert property (@(posedge clk) disable iff (!arst_n)
    wdi_fall |-> !wdi_s);
endmodule

bind wake_watch_sup wake_watch_sup_chk u_chk (
  .clk(clk), .arst_n(arst_n), .tick(tick), .pg_s(pg_s), .wdi_s(wdi_s),
  .wdi_fall(wdi_fall), .miss(miss), .wakeup(wakeup), .reset_n(reset_n)
);

// File: tb/wake_watch_sup_test.sv
module wake_watch_sup_test;
  localparam int DIV = 4;
  localparam int T   = 32;
  localparam int F   = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic power_good = 1'b0;
  logic wdi = 1'b1;
  logic wakeup, reset_n;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  wake_watch_sup #(.TICK_DIV(DIV), .PERIOD_TICKS(T), .WDI_FILT(F)) uut (
    .clk(clk), .arst_n(arst_n), .power_good(power_good), .wdi(wdi),
    .wakeup(wakeup), .reset_n(reset_n)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // expected intervals in clocks, from the requirements
  function automatic int period_clks();  return T * DIV; endfunction
  function automatic int high_clks();    return (T * DIV) >> 1; endfunction
  function automatic int pulse_clks();   return (T >> 3) * DIV; endfunction
  function automatic int kick_lat();     return F + 2; endfunction
  function automatic int rel_lo();       return pulse_clks() - DIV + 3; endfunction
  function automatic int rel_hi();       return pulse_clks() + 2; endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sel 0: wakeup, sel 1: reset_n
  task automatic wait_val(input int sel, input logic v, input int maxc, input string req);
    int n = 0;
    while (((sel == 0) ? wakeup : reset_n) !== v && n < maxc) begin
      @(negedge clk);
      n++;
    end
    if (n >= maxc) chk(1'b0, req, "timeout waiting for level", n, maxc);
  endtask

  task automatic pulse(input int len);
    wdi = 1'b0;
    repeat (len) @(negedge clk);
    wdi = 1'b1;
    repeat (len) @(negedge clk);
  endtask

  // after reset_n has fallen: check pulse width, wakeup low, restart gap
  task automatic recover();
    int tf = cyc;
    int t1;
    bit bad = 1'b0;
    int n = 0;
    while (reset_n == 1'b0 && n < 400) begin
      if (wakeup !== 1'b0) bad = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(!bad, "R8", "wakeup during reset", int'(bad), 0);
    chk(cyc - tf == pulse_clks(), "R7", "reset width", cyc - tf, pulse_clks());
    t1 = cyc;
    wait_val(0, 1'b1, 400, "R3");
    chk(cyc - t1 == high_clks(), "R3", "reset high to wakeup", cyc - t1, high_clks());
  endtask

  // entered at the negedge right after a wakeup rise
  // mode 0: respond in low phase, 1: in high phase, 2: none, 3: two responses
  task automatic do_cycle(input int mode, input int off);
    int tr = cyc;
    int ts;
    case (mode)
      0: begin
        wait_val(0, 1'b0, 400, "R4");
        chk(cyc - tr == high_clks(), "R4", "high width", cyc - tr, high_clks());
        repeat (off) @(negedge clk);
        pulse(8);
        wait_val(0, 1'b1, 400, "R4");
        chk(cyc - tr == period_clks(), "R4", "period", cyc - tr, period_clks());
        chk(reset_n == 1'b1, "R4", "no reset with response", int'(reset_n), 1);
      end
      1, 3: begin
        repeat (off) @(negedge clk);
        wdi = 1'b0;
        ts = cyc;
        wait_val(0, 1'b0, 40, "R5");
        chk(cyc - ts == kick_lat(), "R5", "response latency", cyc - ts, kick_lat());
        while (cyc - ts < 8) @(negedge clk);
        wdi = 1'b1;
        if (mode == 3) begin
          repeat (20) @(negedge clk);
          pulse(8);  // second response in the same cycle, R6
        end
        wait_val(0, 1'b1, 400, "R5");
        chk(cyc - tr == period_clks(), "R5", "cycle kept after early drop",
            cyc - tr, period_clks());
        chk(reset_n == 1'b1, "R5", "no reset after response", int'(reset_n), 1);
      end
      default: begin
        wait_val(1, 1'b0, 400, "R7");
        chk(cyc - tr == period_clks(), "R7", "missed response reset time",
            cyc - tr, period_clks());
        recover();
      end
    endcase
  endtask

  initial begin
    int unsigned seed_init;
    int tr, ts, d;
    seed_init = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    chk(reset_n == 1'b0, "R1", "reset_n in reset", int'(reset_n), 0);
    chk(wakeup == 1'b0, "R1", "wakeup in reset", int'(wakeup), 0);
    arst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(reset_n == 1'b0, "R2", "held while power low", int'(reset_n), 0);
    chk(wakeup == 1'b0, "R8", "wakeup while power low", int'(wakeup), 0);

    power_good = 1'b1;
    ts = cyc;
    wait_val(1, 1'b1, 400, "R2");
    d = cyc - ts;
    chk(d >= rel_lo() && d <= rel_hi(), "R2", "release delay", d, rel_lo());
    ts = cyc;
    wait_val(0, 1'b1, 400, "R3");
    chk(cyc - ts == high_clks(), "R3", "first wakeup gap", cyc - ts, high_clks());

    do_cycle(0, 10);   // R4
    do_cycle(1, 10);   // R5
    do_cycle(3, 12);   // R6 two responses ...
    do_cycle(2, 0);    // ... then none: must reset (R6, R7)

    // R9: short low glitch is ignored
    tr = cyc;
    repeat (10) @(negedge clk);
    wdi = 1'b0;
    repeat (F - 1) @(negedge clk);
    wdi = 1'b1;
    repeat (12) @(negedge clk);
    chk(wakeup == 1'b1, "R9", "wakeup after glitch", int'(wakeup), 1);
    wait_val(0, 1'b0, 400, "R9");
    chk(cyc - tr == high_clks(), "R9", "high width after glitch", cyc - tr, high_clks());
    repeat (10) @(negedge clk);
    pulse(8);
    wait_val(0, 1'b1, 400, "R9");
    chk(cyc - tr == period_clks(), "R9", "period after glitch", cyc - tr, period_clks());

    // R10: power drop while running
    repeat (10) @(negedge clk);
    power_good = 1'b0;
    ts = cyc;
    wait_val(1, 1'b0, 20, "R10");
    chk(cyc - ts == 3, "R10", "power drop latency", cyc - ts, 3);
    chk(wakeup == 1'b0, "R8", "wakeup after power drop", int'(wakeup), 0);
    repeat (30) @(negedge clk);
    chk(reset_n == 1'b0, "R2", "held while power low", int'(reset_n), 0);
    power_good = 1'b1;
    ts = cyc;
    wait_val(1, 1'b1, 400, "R2");
    d = cyc - ts;
    chk(d >= rel_lo() && d <= rel_hi(), "R2", "release after drop", d, rel_lo());
    ts = cyc;
    wait_val(0, 1'b1, 400, "R3");
    chk(cyc - ts == high_clks(), "R3", "gap after drop", cyc - ts, high_clks());

    // R10: power drop during a watchdog reset restarts the delay
    tr = cyc;
    wait_val(1, 1'b0, 400, "R7");
    chk(cyc - tr == period_clks(), "R7", "missed response reset time", cyc - tr, period_clks());
    repeat (4) @(negedge clk);
    power_good = 1'b0;
    repeat (12) @(negedge clk);
    power_good = 1'b1;
    ts = cyc;
    wait_val(1, 1'b1, 400, "R10");
    d = cyc - ts;
    chk(d >= rel_lo() && d <= rel_hi(), "R10", "restarted delay", d, rel_lo());
    ts = cyc;
    wait_val(0, 1'b1, 400, "R3");
    chk(cyc - ts == high_clks(), "R3", "gap after restarted delay", cyc - ts, high_clks());

    // random mix of cycles
    for (int i = 0; i < 30; i++) begin
      int mode = int'($urandom % 4);
      int off  = 4 + int'($urandom % 37);
      do_cycle(mode, off);
      if (mode == 3) do_cycle(2, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual 200000 expected fewer cycles");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule